// File: doc/BRIEF.md
# Two-Step Precision Time Master Sequencer

This block is the timing engine on the master side of a two-step precision time exchange. It keeps a free-running time-of-day counter, split into seconds and nanoseconds. At a programmable interval it asks a frame builder to send a sync message. When the transmit MAC reports the start of that frame, the block captures the exact counter value. It then asks for a follow-up message that carries the captured time.

On the receive side, every delay request from a slave is stamped with the local time on arrival. The stamp is queued together with the sequence identifier of the request. Each queued entry is later answered with a delay-response message that carries the stamp and echoes the identifier.

All messages leave through a single request/acknowledge handshake. Frame encoding, MAC logic and queue priority belong to the surrounding blocks.

Top module: `ptp_master_seq`

## Requirements
- R1: After reset the time reads 0 s, 0 ns. Each clock cycle adds TICK_NS to the nanoseconds field. When the sum reaches NS_WRAP, the field drops by NS_WRAP and the seconds field increments by one.
- R2: With a non-zero `syncInterval` of N, consecutive sync requests rise exactly N cycles apart while the sequencer is otherwise idle. With a value of 0, no sync request is ever raised.
- R3: While `txReq` is high and `txAck` is low, `txType`, `txSeqId`, `txSec` and `txNs` hold their values into the next cycle. A message counts as sent on a clock edge where both `txReq` and `txAck` are high.
- R4: The follow-up carries the time value present in the cycle in which `txSofStrobe` was high. The strobe is honoured on any of the TIMEOUT_CYC cycles after the sync was acknowledged, including the last one.
- R5: A follow-up is requested only after the start-of-frame strobe. If no strobe is seen within TIMEOUT_CYC cycles of the sync acknowledge, `syncLost` pulses high for exactly one cycle. In that case no follow-up is sent and the sequencer returns to idle.
- R6: The sequence identifier is 0 after reset. The sync and follow-up of one exchange share it. It increments by one when each exchange ends, whether the exchange completes or is abandoned.
- R7: A delay request stamps the current time when `rxDreqStrobe` is high. Each delay response carries that stamp and echoes the request's `rxDreqSeqId`. Responses go out in arrival order.
- R8: Up to QUEUE_DEPTH (2) delay requests wait for a response. A request that arrives while the queue is full is dropped and `dropCount` increments by one, unless an entry leaves on the same edge.
- R9: `txType` encodes sync as 0, follow-up as 1 and delay response as 2; the value 3 never appears with `txReq`. A sync message carries all-zero time fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, one time tick per cycle |
| rstN | input | 1 | Active-low asynchronous reset |
| syncInterval | input | INTERVAL_W | Cycles between sync messages; 0 disables them |
| txReq | output | 1 | Message request toward the frame builder |
| txType | output | 2 | Message kind (R9 encoding) |
| txSeqId | output | SEQ_W | Sequence identifier for the message |
| txSec | output | SEC_W | Seconds payload |
| txNs | output | NS_W | Nanoseconds payload |
| txAck | input | 1 | Frame builder accepts the request |
| txSofStrobe | input | 1 | Transmit start-of-frame of the sync message |
| rxDreqStrobe | input | 1 | Delay request arrival pulse |
| rxDreqSeqId | input | SEQ_W | Sequence identifier of the arriving request |
| nowSec | output | SEC_W | Current seconds |
| nowNs | output | NS_W | Current nanoseconds |
| syncLost | output | 1 | One-cycle pulse when a sync timestamp never came |
| dropCount | output | DROP_W | Number of delay requests discarded |

## Verification
The time outputs change one edge after each cycle, so the model advances its own count after every comparison.

A timestamp taken from a strobe equals the time that was visible in the cycle the strobe was driven. The model records that value at the moment it drives the strobe.

A timeout pulse is expected TIMEOUT_CYC+1 cycles after the cycle in which the sync acknowledge was driven. A follow-up request appears one cycle after a strobe. The sync gap is measured from one request rise to the next and must equal the interval.

// File: rtl/ptpm_pkg.sv
package ptpm_pkg;

  typedef enum logic [1:0] {
    MSG_SYNC   = 2'd0,
    MSG_FOLLOW = 2'd1,
    MSG_DRESP  = 2'd2
  } msg_kind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic startSync;
    logic latchSof;
    logic advanceSeq;
    logic popQueue;
  } ctrl_strobes_t;

endpackage

// File: rtl/ptpm_ctrl.sv
module ptpm_ctrl
  import ptpm_pkg::*;
#(
  parameter int TIMEOUT_CYC = 64
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          syncDue,
  input  logic          queueNonEmpty,
  input  logic          txAck,
  input  logic          txSofStrobe,
  output logic          txReq,
  output msg_kind_e     txKind,
  output ctrl_strobes_t strb,
  output logic          syncLost
);

  localparam int TW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [TW-1:0] LAST = TW'(TIMEOUT_CYC - 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SYNC,
    ST_WAIT,
    ST_FUP,
    ST_DRESP
  } state_e;

  state_e state, stateNext;
  logic [TW-1:0] timer;

  always_comb begin
    stateNext = state;
    strb      = '0;
    unique case (state)
      ST_IDLE: begin
        if (syncDue) begin
          stateNext      = ST_SYNC;
          strb.startSync = 1'b1;
        end else if (queueNonEmpty) begin
          stateNext = ST_DRESP;
        end
      end
      ST_SYNC: if (txAck) stateNext = ST_WAIT;
      ST_WAIT: begin
        if (txSofStrobe) begin
          stateNext     = ST_FUP;
          strb.latchSof = 1'b1;
        end else if (timer == LAST) begin
          stateNext       = ST_IDLE;
          strb.advanceSeq = 1'b1;
        end
      end
      ST_FUP: begin
        if (txAck) begin
          stateNext       = ST_IDLE;
          strb.advanceSeq = 1'b1;
        end
      end
      ST_DRESP: begin
        if (txAck) begin
          stateNext     = ST_IDLE;
          strb.popQueue = 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      timer    <= '0;
      syncLost <= 1'b0;
    end else begin
      state    <= stateNext;
      syncLost <= (state == ST_WAIT) && !txSofStrobe && (timer == LAST);
      if (state != ST_WAIT) timer <= '0;
      else                  timer <= timer + 1'b1;
    end
  end

  assign txReq = (state == ST_SYNC) || (state == ST_FUP) || (state == ST_DRESP);

  always_comb begin
    unique case (state)
      ST_FUP:   txKind = MSG_FOLLOW;
      ST_DRESP: txKind = MSG_DRESP;
      default:  txKind = MSG_SYNC;
    endcase
  end

endmodule

// File: rtl/ptpm_datapath.sv
module ptpm_datapath
  import ptpm_pkg::*;
#(
  parameter int SEC_W       = 32,
  parameter int NS_W        = 30,
  parameter int SEQ_W       = 16,
  parameter int DROP_W      = 16,
  parameter int INTERVAL_W  = 24,
  parameter int TICK_NS     = 8,
  parameter int NS_WRAP     = 1000000000,
  parameter int QUEUE_DEPTH = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [INTERVAL_W-1:0] syncInterval,
  input  ctrl_strobes_t         strb,
  input  msg_kind_e             txKind,
  input  logic                  rxDreqStrobe,
  input  logic [SEQ_W-1:0]      rxDreqSeqId,
  output logic                  syncDue,
  output logic                  queueNonEmpty,
  output logic [SEQ_W-1:0]      txSeqId,
  output logic [SEC_W-1:0]      txSec,
  output logic [NS_W-1:0]       txNs,
  output logic [SEC_W-1:0]      nowSec,
  output logic [NS_W-1:0]       nowNs,
  output logic [DROP_W-1:0]     dropCount
);

  localparam int PW = (QUEUE_DEPTH > 1) ? $clog2(QUEUE_DEPTH) : 1;
  localparam int CW = $clog2(QUEUE_DEPTH + 1);
  localparam logic [NS_W:0] WRAP_V = (NS_W + 1)'(NS_WRAP);
  localparam logic [NS_W:0] TICK_V = (NS_W + 1)'(TICK_NS);
  localparam logic [CW-1:0] FULL_V = CW'(QUEUE_DEPTH);
  localparam logic [PW-1:0] LASTP  = PW'(QUEUE_DEPTH - 1);

  // time of day
  logic [NS_W:0] nsSum;
  assign nsSum = {1'b0, nowNs} + TICK_V;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nowNs  <= '0;
      nowSec <= '0;
    end else if (nsSum >= WRAP_V) begin
      nowNs  <= NS_W'(nsSum - WRAP_V);
      nowSec <= nowSec + 1'b1;
    end else begin
      nowNs <= nsSum[NS_W-1:0];
    end
  end

  // sync interval pacing
  logic [INTERVAL_W-1:0] ivCount;
  logic                  ivHit;
  assign ivHit = (syncInterval != '0) && (ivCount >= syncInterval - 1'b1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ivCount <= '0;
      syncDue <= 1'b0;
    end else begin
      if (syncInterval == '0 || ivHit) ivCount <= '0;
      else                             ivCount <= ivCount + 1'b1;
      if (strb.startSync) syncDue <= 1'b0;
      if (ivHit)          syncDue <= 1'b1;
    end
  end

  // sync timestamp and exchange identifier
  logic [SEC_W-1:0] sofSec;
  logic [NS_W-1:0]  sofNs;
  logic [SEQ_W-1:0] seqId;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sofSec <= '0;
      sofNs  <= '0;
      seqId  <= '0;
    end else begin
      if (strb.latchSof) begin
        sofSec <= nowSec;
        sofNs  <= nowNs;
      end
      if (strb.advanceSeq) seqId <= seqId + 1'b1;
    end
  end

  // delay request queue
  logic [QUEUE_DEPTH-1:0][SEQ_W-1:0] qSeq;
  logic [QUEUE_DEPTH-1:0][SEC_W-1:0] qSec;
  logic [QUEUE_DEPTH-1:0][NS_W-1:0]  qNs;
  logic [PW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] qCount;
  logic push, pop, drop;

  assign pop   = strb.popQueue && (qCount != '0);
  assign push  = rxDreqStrobe && ((qCount != FULL_V) || pop);
  assign drop  = rxDreqStrobe && !push;
  assign queueNonEmpty = (qCount != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      qSeq      <= '0;
      qSec      <= '0;
      qNs       <= '0;
      wrPtr     <= '0;
      rdPtr     <= '0;
      qCount    <= '0;
      dropCount <= '0;
    end else begin
      for (int i = 0; i < QUEUE_DEPTH; i++) begin
        if (push && wrPtr == PW'(i)) begin
          qSeq[i] <= rxDreqSeqId;
          qSec[i] <= nowSec;
          qNs[i]  <= nowNs;
        end
      end
      if (push) wrPtr <= (wrPtr == LASTP) ? '0 : wrPtr + 1'b1;
      if (pop)  rdPtr <= (rdPtr == LASTP) ? '0 : rdPtr + 1'b1;
      if (push && !pop)      qCount <= qCount + 1'b1;
      else if (pop && !push) qCount <= qCount - 1'b1;
      if (drop) dropCount <= dropCount + 1'b1;
    end
  end

  // outgoing payload
  always_comb begin
    unique case (txKind)
      MSG_FOLLOW: begin
        txSeqId = seqId;
        txSec   = sofSec;
        txNs    = sofNs;
      end
      MSG_DRESP: begin
        txSeqId = qSeq[rdPtr];
        txSec   = qSec[rdPtr];
        txNs    = qNs[rdPtr];
      end
      default: begin
        txSeqId = seqId;
        txSec   = '0;
        txNs    = '0;
      end
    endcase
  end

endmodule

// File: rtl/ptp_master_seq.sv
module ptp_master_seq
  import ptpm_pkg::*;
#(
  parameter int SEC_W       = 32,
  parameter int NS_W        = 30,
  parameter int SEQ_W       = 16,
  parameter int DROP_W      = 16,
  parameter int INTERVAL_W  = 24,
  parameter int TICK_NS     = 8,
  parameter int NS_WRAP     = 1000000000,
  parameter int TIMEOUT_CYC = 64,
  parameter int QUEUE_DEPTH = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [INTERVAL_W-1:0] syncInterval,
  output logic                  txReq,
  output logic [1:0]            txType,
  output logic [SEQ_W-1:0]      txSeqId,
  output logic [SEC_W-1:0]      txSec,
  output logic [NS_W-1:0]       txNs,
  input  logic                  txAck,
  input  logic                  txSofStrobe,
  input  logic                  rxDreqStrobe,
  input  logic [SEQ_W-1:0]      rxDreqSeqId,
  output logic [SEC_W-1:0]      nowSec,
  output logic [NS_W-1:0]       nowNs,
  output logic                  syncLost,
  output logic [DROP_W-1:0]     dropCount
);

  ctrl_strobes_t strb;
  msg_kind_e     txKind;
  logic          syncDue;
  logic          queueNonEmpty;

  ptpm_ctrl #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .syncDue      (syncDue),
    .queueNonEmpty(queueNonEmpty),
    .txAck        (txAck),
    .txSofStrobe  (txSofStrobe),
    .txReq        (txReq),
    .txKind       (txKind),
    .strb         (strb),
    .syncLost     (syncLost)
  );

  ptpm_datapath #(
    .SEC_W(SEC_W), .NS_W(NS_W), .SEQ_W(SEQ_W), .DROP_W(DROP_W),
    .INTERVAL_W(INTERVAL_W), .TICK_NS(TICK_NS), .NS_WRAP(NS_WRAP),
    .QUEUE_DEPTH(QUEUE_DEPTH)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .syncInterval (syncInterval),
    .strb         (strb),
    .txKind       (txKind),
    .rxDreqStrobe (rxDreqStrobe),
    .rxDreqSeqId  (rxDreqSeqId),
    .syncDue      (syncDue),
    .queueNonEmpty(queueNonEmpty),
    .txSeqId      (txSeqId),
    .txSec        (txSec),
    .txNs         (txNs),
    .nowSec       (nowSec),
    .nowNs        (nowNs),
    .dropCount    (dropCount)
  );

  assign txType = txKind;

endmodule

// File: rtl/ptpm_checker.sv
module ptpm_checker #(
  parameter int SEC_W   = 32,
  parameter int NS_W    = 30,
  parameter int SEQ_W   = 16,
  parameter int DROP_W  = 16,
  parameter int TICK_NS = 8,
  parameter int NS_WRAP = 1000000000
) (
  input logic              clk,
  input logic              rstN,
  input logic              txReq,
  input logic [1:0]        txType,
  input logic [SEQ_W-1:0]  txSeqId,
  input logic [SEC_W-1:0]  txSec,
  input logic [NS_W-1:0]   txNs,
  input logic              txAck,
  input logic [SEC_W-1:0]  nowSec,
  input logic [NS_W-1:0]   nowNs,
  input logic              syncLost,
  input logic [DROP_W-1:0] dropCount
);

  assert_ns_below_wrap_R1: assert property (@(posedge clk) disable iff (!rstN)
    longint'(nowNs) < longint'(NS_WRAP));

  assert_sec_carry_R1: assert property (@(posedge clk) disable iff (!rstN)
    (longint'(nowNs) + longint'(TICK_NS) >= longint'(NS_WRAP))
      |=> (nowSec == $past(nowSec) + SEC_W'(1)));

  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (txReq && !txAck) |=> (txReq && $stable(txType) && $stable(txSeqId)
                           && $stable(txSec) && $stable(txNs)));

  assert_lost_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    syncLost |=> !syncLost);

  assert_no_follow_on_loss_R5: assert property (@(posedge clk) disable iff (!rstN)
    syncLost |-> !(txReq && txType == 2'd1));

  assert_drop_step_R8: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((dropCount == $past(dropCount)) ||
              (dropCount == $past(dropCount) + DROP_W'(1))));

  assert_type_legal_R9: assert property (@(posedge clk) disable iff (!rstN)
    txReq |-> (txType != 2'd3));

endmodule

bind ptp_master_seq ptpm_checker #(
  .SEC_W(SEC_W), .NS_W(NS_W), .SEQ_W(SEQ_W), .DROP_W(DROP_W),
  .TICK_NS(TICK_NS), .NS_WRAP(NS_WRAP)
) u_chk (
  .clk(clk), .rstN(rstN), .txReq(txReq), .txType(txType), .txSeqId(txSeqId),
  .txSec(txSec), .txNs(txNs), .txAck(txAck), .nowSec(nowSec), .nowNs(nowNs),
  .syncLost(syncLost), .dropCount(dropCount)
);

// File: tb/tb_ptp_master_seq.sv
module tb_ptp_master_seq;

  localparam int TICK = 8;
  localparam int WRAP = 420;
  localparam int TO   = 16;
  localparam int IVW  = 16;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic            rstN = 1'b0;
  logic [IVW-1:0]  syncInterval = '0;
  logic            txReq;
  logic [1:0]      txType;
  logic [15:0]     txSeqId;
  logic [31:0]     txSec;
  logic [29:0]     txNs;
  logic            txAck = 1'b0;
  logic            txSofStrobe = 1'b0;
  logic            rxDreqStrobe = 1'b0;
  logic [15:0]     rxDreqSeqId = '0;
  logic [31:0]     nowSec;
  logic [29:0]     nowNs;
  logic            syncLost;
  logic [15:0]     dropCount;

  ptp_master_seq #(
    .INTERVAL_W(IVW), .TICK_NS(TICK), .NS_WRAP(WRAP), .TIMEOUT_CYC(TO)
  ) dut (.*);

  int nChecks = 0;
  int nFail   = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference state
  longint mNs = 0, mSec = 0, sofNs = 0, sofSec = 0;
  int     mSeq = 0, phase = 0, waitCnt = 0, mDrop = 0;
  int     syncCount = 0, reqAge = 0, cyc = 0, lastRise = -1, lastIv = 0;
  int     curSof = 0, curDreq = 0, curAck = 0, dreqTag = 256;
  bit     prevSyncReq = 0, heldPrev = 0;
  logic [1:0]  hType;
  logic [15:0] hSeq;
  logic [29:0] hNs;
  int     qSeqM[$];
  longint qNsM[$], qSecM[$];

  always @(negedge clk) begin
    if (!rstN) begin
      check(txReq == 1'b0, "R9 reset txReq", txReq, 0);
      check(nowNs == 0 && nowSec == 0, "R1 reset time", nowNs, 0);
      check(dropCount == 0, "R8 reset drops", dropCount, 0);
      check(syncLost == 1'b0, "R5 reset lost", syncLost, 0);
      check(txSeqId == 0, "R6 reset seq", txSeqId, 0);
    end else begin
      bit expLost, curSyncReq;
      cyc++;
      check(longint'(nowNs) == mNs, "R1 nanoseconds", nowNs, mNs);
      check(longint'(nowSec) == mSec, "R1 seconds", nowSec, mSec);
      check(int'(dropCount) == mDrop, "R8 drop count", dropCount, mDrop);

      expLost = 0;
      if (phase == 1) begin
        waitCnt++;
        if (waitCnt == TO + 1) begin
          expLost = 1;
          phase = 0;
          mSeq = (mSeq + 1) & 16'hFFFF;
        end
      end
      check(syncLost == expLost, "R5 timeout pulse", syncLost, expLost);

      curSyncReq = txReq && txType == 2'd0;
      if (curSyncReq && !prevSyncReq) begin
        if (syncInterval == 0) check(0, "R2 sync with zero interval", 1, 0);
        else if (lastRise >= 0 && lastIv == int'(syncInterval))
          check(cyc - lastRise == int'(syncInterval), "R2 sync spacing", cyc - lastRise, syncInterval);
        lastRise = cyc;
        lastIv = syncInterval;
      end
      prevSyncReq = curSyncReq;

      if (txReq && heldPrev) begin
        check(txType == hType && txSeqId == hSeq && txNs == hNs, "R3 held fields", txSeqId, hSeq);
      end

      txAck = 1'b0;
      heldPrev = 0;
      if (txReq) begin
        if (reqAge >= curAck) begin
          txAck = 1'b1;
          reqAge = 0;
          case (txType)
            2'd0: begin
              check(phase == 0, "R9 sync outside exchange", phase, 0);
              check(int'(txSeqId) == mSeq, "R6 sync seq", txSeqId, mSeq);
              check(txSec == 0 && txNs == 0, "R9 sync payload zero", txNs, 0);
              phase = 1;
              waitCnt = 0;
              case (syncCount)
                0: begin curSof = 3;  curDreq = 0; curAck = 0; end
                1: begin curSof = 1;  curDreq = 1; curAck = 1; end
                2: begin curSof = 0;  curDreq = 2; curAck = 0; end
                3: begin curSof = TO; curDreq = 3; curAck = 2; end
                4: begin curSof = 5;  curDreq = 2; curAck = 2; end
                5: begin curSof = 0;  curDreq = 3; curAck = 0; end
                default: begin curSof = 7; curDreq = 1; curAck = 1; end
              endcase
              syncCount++;
            end
            2'd1: begin
              check(phase == 2, "R5 follow-up only after strobe", phase, 2);
              check(int'(txSeqId) == mSeq, "R6 follow-up seq", txSeqId, mSeq);
              check(longint'(txNs) == sofNs, "R4 follow-up ns", txNs, sofNs);
              check(longint'(txSec) == sofSec, "R4 follow-up sec", txSec, sofSec);
              mSeq = (mSeq + 1) & 16'hFFFF;
              phase = 0;
            end
            2'd2: begin
              check(qSeqM.size() > 0, "R7 response with pending request", qSeqM.size(), 1);
              if (qSeqM.size() > 0) begin
                check(int'(txSeqId) == qSeqM[0], "R7 echoed seq", txSeqId, qSeqM[0]);
                check(longint'(txNs) == qNsM[0], "R7 arrival ns", txNs, qNsM[0]);
                check(longint'(txSec) == qSecM[0], "R7 arrival sec", txSec, qSecM[0]);
                void'(qSeqM.pop_front());
                void'(qNsM.pop_front());
                void'(qSecM.pop_front());
              end
            end
            default: check(0, "R9 illegal type", txType, 0);
          endcase
        end else begin
          reqAge++;
          heldPrev = 1;
          hType = txType;
          hSeq = txSeqId;
          hNs = txNs;
        end
      end else begin
        reqAge = 0;
      end

      rxDreqStrobe = 1'b0;
      if (phase == 1 && waitCnt >= 1 && waitCnt <= curDreq) begin
        rxDreqStrobe = 1'b1;
        rxDreqSeqId = 16'(dreqTag);
        if (qSeqM.size() < 2) begin
          qSeqM.push_back(dreqTag);
          qNsM.push_back(mNs);
          qSecM.push_back(mSec);
        end else begin
          mDrop++;
        end
        dreqTag++;
      end

      txSofStrobe = 1'b0;
      if (phase == 1 && curSof != 0 && waitCnt == curSof) begin
        txSofStrobe = 1'b1;
        sofNs = mNs;
        sofSec = mSec;
        phase = 2;
      end

      mNs += TICK;
      if (mNs >= WRAP) begin
        mNs -= WRAP;
        mSec++;
      end
    end
  end

  initial begin
    bit timedOut = 0;
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    repeat (100) @(posedge clk);
    #1 syncInterval = 16'd60;
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
      if (syncCount >= 9 && phase == 0 && qSeqM.size() == 0 && !txReq) break;
      if (i == 19999) timedOut = 1;
    end
    repeat (3) @(negedge clk);
    if (timedOut) check(0, "watchdog expired", cyc, 0);
    check(mDrop == 2, "R8 total drops", mDrop, 2);
    check(int'(dropCount) == 2, "R8 final drop count", dropCount, 2);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule